// File: doc/BRIEF.md
# Single-Wire CAN Transceiver Mode Controller

This block is the digital control core of a single-wire CAN physical layer. It reads two mode-select pins, the transmit data pin, and the digitized flags of the analog front end: bus dominant, wake level present, undervoltage, overtemperature and ground loss. From these it drives the bus-driver controls, the receive data pin, a regulator-enable line and the ground-return switch. Waveshaping, voltages, comparator thresholds, analog filtering and current limiting are outside it.

All asynchronous inputs pass through two-flop synchronizers, so each output reacts on the second clock edge after an input change. Every timed window counts pulses of `tick_i`, which comes from a 500 kHz timebase, so one tick is 2 µs. All ports are plain level signals with no handshake. A module that sleeps with its regulator off is woken when a node raises the bus to wake-up voltage. The regulator-enable line then stays high long enough for the local controller to boot and select an awake mode.

Top module: `swc_mode_ctrl`

## Requirements
- R1: `drv_mode_o` carries the synchronized code {mode1_i, mode0_i}: 2'b00 is sleep, 2'b01 is high speed, 2'b10 is high-voltage wake, and 2'b11 is normal. After reset, the mode is sleep (2'b00).
- R2: Outside sleep and with no fault, a low `txd_i` makes `drv_dom_o` and `drv_en_o` high, and a high `txd_i` leaves `drv_dom_o` low. In sleep, `drv_dom_o` and `drv_en_o` are both low.
- R3: After the last dominant bit, `drv_en_o` stays high for TX_HOLD_TICKS ticks and then goes low.
- R4: In any awake mode with no undervoltage, `rxd_o` is the inverse of `bus_dom_i`.
- R5: In sleep, `rxd_o` is high while no wake level is present. While `hv_wake_i` is high, `rxd_o` follows the bus. It keeps following the bus for RX_TAIL_TICKS ticks after the wake level ends, and then it is released high.
- R6: A rising `hv_wake_i` in sleep drives `reg_en_o` high. `reg_en_o` stays high while the mode is not sleep.
- R7: In sleep, `reg_en_o` goes low REG_HOLD_TICKS ticks after the last wake edge or awake mode, even when the wake level is still present.
- R8: Undervoltage (`uv_i` high) forces `drv_en_o` and `drv_dom_o` low and `rxd_o` high.
- R9: Overtemperature (`ot_i` high) forces `drv_en_o` and `drv_dom_o` low and leaves `rxd_o` following the bus.
- R10: `gnd_sw_en_o` is high in every mode and is low only while `gnd_loss_i` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | One-cycle pulse from the 500 kHz timebase |
| mode0_i | input | 1 | Mode select, low bit |
| mode1_i | input | 1 | Mode select, high bit |
| txd_i | input | 1 | Transmit data (0 = dominant) |
| bus_dom_i | input | 1 | Bus comparator: bus is dominant |
| hv_wake_i | input | 1 | Wake-up voltage level present on the bus |
| uv_i | input | 1 | Supply undervoltage flag |
| ot_i | input | 1 | Overtemperature flag |
| gnd_loss_i | input | 1 | Loss of module ground flag |
| rxd_o | output | 1 | Receive data (1 = recessive or released) |
| drv_en_o | output | 1 | Bus driver enable |
| drv_dom_o | output | 1 | Drive the bus dominant |
| drv_mode_o | output | 2 | Drive level and waveshape select (mode code) |
| reg_en_o | output | 1 | Regulator enable |
| gnd_sw_en_o | output | 1 | Ground-return switch closed |

## Verification
The transmit and receive paths are exercised in each awake mode with the transmit bit and the bus flag toggled. This separates the mode code from the data path and shows that the receive output inverts the bus rather than echoing the transmit pin. In sleep, the bus is driven dominant first without the wake level, then with it, and then after it is gone. These three cases separate the released output, the wake-time following and the timed tail. The regulator line is checked early and late in its window, once after an awake mode and once with a wake level that persists. This tells a timed fall apart from a fall that waits for the wake level to clear. Undervoltage and overtemperature are each applied with a dominant transmit bit, which shows which of the two paths each fault gates.

// File: rtl/swc_pkg.sv
package swc_pkg;
  typedef enum logic [1:0] {
    MODE_SLEEP = 2'b00,
    MODE_HSPD  = 2'b01,
    MODE_HVWU  = 2'b10,
    MODE_NORM  = 2'b11
  } swc_mode_e;

  // synchronized input vector bit positions
  localparam int unsigned SI_MODE1 = 7;
  localparam int unsigned SI_MODE0 = 6;
  localparam int unsigned SI_TXD   = 5;
  localparam int unsigned SI_BUS   = 4;
  localparam int unsigned SI_HV    = 3;
  localparam int unsigned SI_UV    = 2;
  localparam int unsigned SI_OT    = 1;
  localparam int unsigned SI_GND   = 0;
  localparam int unsigned SI_W     = 8;
endpackage

// File: rtl/swc_sync.sv
module swc_sync #(
  parameter int unsigned    W       = 8,
  parameter logic [W-1:0]   RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q, stab_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= RST_VAL;
      stab_q <= RST_VAL;
    end else begin
      meta_q <= d_i;
      stab_q <= meta_q;
    end
  end

  assign q_o = stab_q;
endmodule

// File: rtl/swc_hold_cnt.sv
module swc_hold_cnt #(
  parameter int unsigned MAX = 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_i,
  input  logic load_i,
  input  logic clr_i,
  output logic busy_o
);
  localparam int unsigned W = (MAX < 2) ? 1 : $clog2(MAX + 1);
  localparam logic [W-1:0] LOAD_VAL = W'(MAX);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      cnt_q <= '0;
    else if (clr_i)                  cnt_q <= '0;
    else if (load_i)                 cnt_q <= LOAD_VAL;
    else if (tick_i && cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign busy_o = (cnt_q != '0);
endmodule

// File: rtl/swc_mode_ctrl.sv
module swc_mode_ctrl
  import swc_pkg::*;
#(
  parameter int unsigned TX_HOLD_TICKS  = 4,
  parameter int unsigned RX_TAIL_TICKS  = 20,
  parameter int unsigned REG_HOLD_TICKS = 250000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_i,
  input  logic       mode0_i,
  input  logic       mode1_i,
  input  logic       txd_i,
  input  logic       bus_dom_i,
  input  logic       hv_wake_i,
  input  logic       uv_i,
  input  logic       ot_i,
  input  logic       gnd_loss_i,
  output logic       rxd_o,
  output logic       drv_en_o,
  output logic       drv_dom_o,
  output logic [1:0] drv_mode_o,
  output logic       reg_en_o,
  output logic       gnd_sw_en_o
);
  localparam logic [SI_W-1:0] SYNC_RST = SI_W'(1) << SI_TXD;

  logic [SI_W-1:0] raw_in, s_in;
  swc_mode_e       mode;
  logic            sleep, tx_ok, tx_dom, hv_d_q, wake_edge;
  logic            tx_busy, rx_tail, rx_open;

  assign raw_in[SI_MODE1] = mode1_i;
  assign raw_in[SI_MODE0] = mode0_i;
  assign raw_in[SI_TXD]   = txd_i;
  assign raw_in[SI_BUS]   = bus_dom_i;
  assign raw_in[SI_HV]    = hv_wake_i;
  assign raw_in[SI_UV]    = uv_i;
  assign raw_in[SI_OT]    = ot_i;
  assign raw_in[SI_GND]   = gnd_loss_i;

  swc_sync #(.W(SI_W), .RST_VAL(SYNC_RST)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_i(raw_in), .q_o(s_in)
  );

  assign mode  = swc_mode_e'({s_in[SI_MODE1], s_in[SI_MODE0]});
  assign sleep = (mode == MODE_SLEEP);

  // transmit path
  assign tx_ok  = !sleep && !s_in[SI_UV] && !s_in[SI_OT];
  assign tx_dom = tx_ok && !s_in[SI_TXD];

  swc_hold_cnt #(.MAX(TX_HOLD_TICKS)) u_tx_hold (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i),
    .load_i(tx_dom), .clr_i(!tx_ok), .busy_o(tx_busy)
  );

  assign drv_dom_o  = tx_dom;
  assign drv_en_o   = tx_ok && (tx_dom || tx_busy);
  assign drv_mode_o = mode;

  // wake edge detection
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hv_d_q <= 1'b0;
    else        hv_d_q <= s_in[SI_HV];
  end
  assign wake_edge = sleep && s_in[SI_HV] && !hv_d_q;

  // regulator enable window
  swc_hold_cnt #(.MAX(REG_HOLD_TICKS)) u_reg_hold (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i),
    .load_i(!sleep || wake_edge), .clr_i(1'b0), .busy_o(reg_en_o)
  );

  // receive path, with sleep tail after the wake level ends
  swc_hold_cnt #(.MAX(RX_TAIL_TICKS)) u_rx_tail (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i),
    .load_i(s_in[SI_HV]), .clr_i(1'b0), .busy_o(rx_tail)
  );

  assign rx_open     = !sleep || s_in[SI_HV] || rx_tail;
  assign rxd_o       = s_in[SI_UV] ? 1'b1 : (rx_open ? !s_in[SI_BUS] : 1'b1);
  assign gnd_sw_en_o = !s_in[SI_GND];
endmodule

// File: rtl/swc_mode_ctrl_chk.sv
module swc_mode_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       bus_dom_i,
  input logic       uv_i,
  input logic       ot_i,
  input logic       gnd_loss_i,
  input logic       rxd_o,
  input logic       drv_en_o,
  input logic [1:0] drv_mode_o,
  input logic       reg_en_o,
  input logic       gnd_sw_en_o
);
  logic [1:0] age_q;
  logic       aged;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              age_q <= 2'd0;
    else if (age_q != 2'd3)  age_q <= age_q + 2'd1;
  end
  assign aged = (age_q == 2'd3);

  a_r10_ground_switch: assert property (@(posedge clk) disable iff (!rst_n)
    aged |-> (gnd_sw_en_o == !$past(gnd_loss_i, 2)));

  a_r8_undervoltage: assert property (@(posedge clk) disable iff (!rst_n)
    (aged && $past(uv_i, 2)) |-> (rxd_o && !drv_en_o));

  a_r9_overtemp: assert property (@(posedge clk) disable iff (!rst_n)
    (aged && $past(ot_i, 2)) |-> !drv_en_o);

  a_r2_sleep_no_drive: assert property (@(posedge clk) disable iff (!rst_n)
    (drv_mode_o == 2'b00) |-> !drv_en_o);

  a_r6_awake_reg_on: assert property (@(posedge clk) disable iff (!rst_n)
    (drv_mode_o != 2'b00) |=> reg_en_o);

  a_r4_awake_rx: assert property (@(posedge clk) disable iff (!rst_n)
    (aged && drv_mode_o != 2'b00 && !$past(uv_i, 2)) |-> (rxd_o == !$past(bus_dom_i, 2)));
endmodule

bind swc_mode_ctrl swc_mode_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bus_dom_i(bus_dom_i), .uv_i(uv_i), .ot_i(ot_i),
  .gnd_loss_i(gnd_loss_i), .rxd_o(rxd_o), .drv_en_o(drv_en_o),
  .drv_mode_o(drv_mode_o), .reg_en_o(reg_en_o), .gnd_sw_en_o(gnd_sw_en_o)
);

// File: tb/tb_swc_mode_ctrl.sv
module tb_swc_mode_ctrl;
  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0;
  logic mode0, mode1, txd, bus_dom, hv, uv, ot, gnd_loss;
  logic rxd, drv_en, drv_dom, reg_en, gnd_sw;
  logic [1:0] drv_mode;

  typedef struct packed {
    logic       rxd;
    logic       en;
    logic       dom;
    logic [1:0] mode;
    logic       reg_en;
    logic       gsw;
  } obs_t;

  obs_t  exp_q[$];
  string tag_q[$];
  event  chk_ev;
  int    checks = 0, failures = 0;
  bit    done = 1'b0;

  always #5 clk = ~clk;

  swc_mode_ctrl #(.TX_HOLD_TICKS(3), .RX_TAIL_TICKS(4), .REG_HOLD_TICKS(20)) dut (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .mode0_i(mode0), .mode1_i(mode1),
    .txd_i(txd), .bus_dom_i(bus_dom), .hv_wake_i(hv), .uv_i(uv), .ot_i(ot),
    .gnd_loss_i(gnd_loss), .rxd_o(rxd), .drv_en_o(drv_en), .drv_dom_o(drv_dom),
    .drv_mode_o(drv_mode), .reg_en_o(reg_en), .gnd_sw_en_o(gnd_sw)
  );

  // timebase: one tick every 4 clocks
  initial begin
    forever begin
      repeat (3) @(negedge clk);
      tick = 1'b1;
      @(negedge clk);
      tick = 1'b0;
    end
  end

  // monitor: pops the expected item and compares it with the ports
  initial begin
    forever begin
      obs_t  e, a;
      string t;
      @(chk_ev);
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      a = '{rxd, drv_en, drv_dom, drv_mode, reg_en, gnd_sw};
      checks++;
      if (a !== e) begin
        failures++;
        $display("FAIL %s actual rxd/en/dom/mode/reg/gsw=%b expected=%b", t, a, e);
      end
    end
  end

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_obs(input logic r, input logic en, input logic dm,
                            input logic [1:0] md, input logic rg, input logic gs,
                            input string t);
    exp_q.push_back('{r, en, dm, md, rg, gs});
    tag_q.push_back(t);
    -> chk_ev;
    #1;
  endtask

  task automatic set_mode(input logic [1:0] m);
    mode1 = m[1];
    mode0 = m[0];
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    set_mode(2'b00); txd = 1'b1; bus_dom = 1'b0; hv = 1'b0;
    uv = 1'b0; ot = 1'b0; gnd_loss = 1'b0;
    settle(5); rst_n = 1'b1; settle(3);
    expect_obs(1, 0, 0, 2'b00, 0, 1, "R1 reset state is sleep");

    set_mode(2'b11); settle(4);
    expect_obs(1, 0, 0, 2'b11, 1, 1, "R1 R6 normal mode, regulator on");
    txd = 1'b0; bus_dom = 1'b1; settle(4);
    expect_obs(0, 1, 1, 2'b11, 1, 1, "R2 R4 dominant transmit and receive");
    set_mode(2'b01); settle(4);
    expect_obs(0, 1, 1, 2'b01, 1, 1, "R1 high speed code");
    set_mode(2'b10); settle(4);
    expect_obs(0, 1, 1, 2'b10, 1, 1, "R1 wake level code");

    txd = 1'b1; bus_dom = 1'b0; settle(4);
    expect_obs(1, 1, 0, 2'b10, 1, 1, "R3 driver held after recessive");
    settle(24);
    expect_obs(1, 0, 0, 2'b10, 1, 1, "R3 hold expired");

    txd = 1'b0; bus_dom = 1'b1; ot = 1'b1; settle(4);
    expect_obs(0, 0, 0, 2'b10, 1, 1, "R9 overtemp gates driver only");
    ot = 1'b0; settle(4);
    expect_obs(0, 1, 1, 2'b10, 1, 1, "R9 overtemp released");
    uv = 1'b1; settle(4);
    expect_obs(1, 0, 0, 2'b10, 1, 1, "R8 undervoltage gates both paths");
    uv = 1'b0; settle(4);
    expect_obs(0, 1, 1, 2'b10, 1, 1, "R8 undervoltage released");
    gnd_loss = 1'b1; settle(4);
    expect_obs(0, 1, 1, 2'b10, 1, 0, "R10 ground loss opens switch");
    gnd_loss = 1'b0; settle(4);
    expect_obs(0, 1, 1, 2'b10, 1, 1, "R10 switch closed again");

    set_mode(2'b00); settle(4);
    expect_obs(1, 0, 0, 2'b00, 1, 1, "R2 R5 R7 sleep: no drive, rx released, reg held");
    settle(96);
    expect_obs(1, 0, 0, 2'b00, 0, 1, "R7 regulator falls after hold");

    txd = 1'b1; hv = 1'b1; settle(4);
    expect_obs(0, 0, 0, 2'b00, 1, 1, "R5 R6 wake level: rx follows, reg on");
    bus_dom = 1'b0; settle(4);
    expect_obs(1, 0, 0, 2'b00, 1, 1, "R5 rx follows recessive during wake");
    bus_dom = 1'b1; hv = 1'b0; settle(4);
    expect_obs(0, 0, 0, 2'b00, 1, 1, "R5 rx follows in tail");
    settle(28);
    expect_obs(1, 0, 0, 2'b00, 1, 1, "R5 rx released after tail");

    hv = 1'b1; settle(4);
    expect_obs(0, 0, 0, 2'b00, 1, 1, "R6 second wake edge");
    settle(96);
    expect_obs(0, 0, 0, 2'b00, 0, 1, "R7 regulator falls with wake level present");

    settle(2);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule